// File: doc/BRIEF.md
# Interrupt Cause and Mask Group

This block is one group of a per-unit interrupt controller. It collects up to `NUM_SRC` hardware event lines into a sticky cause register. A mask register gates the cause bits into a single group interrupt line. A second mask, kept apart from the first, decides which cause bits drive an abort line that stops the owning unit.

Software reaches the group through a plain strobe interface: a write strobe, a read strobe, a 3-bit register select and a data word. Cause bits can be set and cleared per bit. The mask can be raised per bit through one register and lowered per bit through another, so neither operation needs a read-modify-write. A control word turns on two modes: clear-on-read of the cause register, and automatic masking of a source at the moment it fires.

The group comes out of reset fully masked. Software must unmask sources before any interrupt can reach the output.

Top module: `irq_cause_group`

## Requirements
- R1: After reset the cause register reads 0, the interrupt mask reads all ones, the abort mask reads all ones, the control word reads 0, and `irq_o` and `abort_o` are low.
- R2: A source line sampled high at a clock edge sets its cause bit at that edge, and the bit stays set after the line drops.
- R3: A write to select 1 sets every cause bit whose data bit is 1 and leaves the other cause bits unchanged.
- R4: A write to select 2 clears every cause bit whose data bit is 1. If a source event or a set write hits the same bit in the same cycle, the bit ends up set.
- R5: A write to select 3 sets every interrupt-mask bit whose data bit is 1 and leaves the others unchanged.
- R6: A write to select 4 clears every interrupt-mask bit whose data bit is 1 and leaves the others unchanged.
- R7: `irq_o` is high exactly one cycle after the register state holds any cause bit whose interrupt-mask bit is 0.
- R8: A write to select 5 loads the whole abort mask. `abort_o` is high exactly one cycle after the register state holds any cause bit whose abort-mask bit is 0.
- R9: A read strobe places on `rdata_o`, after the next edge, the pre-edge value of the selected register: select 0 cause, 3 interrupt mask, 5 abort mask, 6 control (bit 0 clear-on-read, bit 1 auto-mask, higher bits 0). Any other select reads 0. `rdata_o` holds between reads.
- R10: With control bit 0 set, a read of select 0 clears the cause bits it returns. A source event on such a bit in the same cycle keeps the bit set.
- R11: With control bit 1 set, a source event sets its own interrupt-mask bit. This wins over a same-cycle select-4 write on that bit, while the write still clears its other bits.
- R12: Writes to select 0 and select 7 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Hardware event lines, one per source |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| addr_i | input | 3 | Register select |
| wdata_i | input | NUM_SRC | Write data |
| rdata_o | output | NUM_SRC | Read data, valid from the edge after the read strobe |
| irq_o | output | 1 | Registered group interrupt |
| abort_o | output | 1 | Registered abort request |

## Verification
Each register write or source event takes effect at the edge where it is sampled. The interrupt and abort outputs follow one edge later, and read data appears at the same edge as the read strobe and shows the value before that edge's update. The bench drives each access on a falling edge and samples one time unit after the next rising edge. At that point it compares `rdata_o` against a model snapshot taken before that edge, and it compares `irq_o` and `abort_o` against the interrupt and abort terms of the same snapshot. The model then advances to the post-edge state, so the one-cycle output lag is checked on every cycle, including cycles where a source event collides with a clear, a clear-on-read or an unmask.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;
   localparam int ADDR_W = 3;
   localparam int CTRL_W = 2;
   localparam int CTRL_COR_BIT  = 0;
   localparam int CTRL_AUTO_BIT = 1;

   typedef enum logic [ADDR_W-1:0] {
      SEL_CAUSE   = 3'd0,
      SEL_C_SET   = 3'd1,
      SEL_C_CLR   = 3'd2,
      SEL_M_SET   = 3'd3,
      SEL_M_CLR   = 3'd4,
      SEL_ABORT   = 3'd5,
      SEL_CTRL    = 3'd6,
      SEL_SPARE   = 3'd7
   } reg_sel_e;
endpackage

// File: rtl/irq_grp_regdec.sv
module irq_grp_regdec
   import irq_grp_pkg::*;
#(
   parameter int NUM_SRC = 32
) (
   input  logic               wr_en_i,
   input  logic               rd_en_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [NUM_SRC-1:0] wdata_i,
   output logic [NUM_SRC-1:0] cset_v_o,
   output logic [NUM_SRC-1:0] cclr_v_o,
   output logic [NUM_SRC-1:0] mset_v_o,
   output logic [NUM_SRC-1:0] mclr_v_o,
   output logic               abrt_wr_o,
   output logic               ctrl_wr_o,
   output logic               rd_cause_o
);
   logic w_cset, w_cclr, w_mset, w_mclr;

   always_comb begin
      w_cset     = wr_en_i && (addr_i == SEL_C_SET);
      w_cclr     = wr_en_i && (addr_i == SEL_C_CLR);
      w_mset     = wr_en_i && (addr_i == SEL_M_SET);
      w_mclr     = wr_en_i && (addr_i == SEL_M_CLR);
      abrt_wr_o  = wr_en_i && (addr_i == SEL_ABORT);
      ctrl_wr_o  = wr_en_i && (addr_i == SEL_CTRL);
      rd_cause_o = rd_en_i && (addr_i == SEL_CAUSE);
      cset_v_o   = w_cset ? wdata_i : '0;
      cclr_v_o   = w_cclr ? wdata_i : '0;
      mset_v_o   = w_mset ? wdata_i : '0;
      mclr_v_o   = w_mclr ? wdata_i : '0;
   end
endmodule

// File: rtl/irq_grp_cause.sv
module irq_grp_cause #(
   parameter int NUM_SRC   = 32,
   parameter bit EDGE_MODE = 1'b0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [NUM_SRC-1:0] set_v_i,
   input  logic [NUM_SRC-1:0] clr_v_i,
   output logic [NUM_SRC-1:0] ev_o,
   output logic [NUM_SRC-1:0] cause_o
);
   logic [NUM_SRC-1:0] cause_q;

   generate
      if (EDGE_MODE) begin : g_edge
         logic [NUM_SRC-1:0] src_d;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) src_d <= '0;
            else         src_d <= src_i;
         end
         assign ev_o = src_i & ~src_d;
      end else begin : g_level
         assign ev_o = src_i;
      end
   endgenerate

   // set and event win over clear on the same bit
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cause_q <= '0;
      else         cause_q <= (cause_q & ~clr_v_i) | set_v_i | ev_o;
   end

   assign cause_o = cause_q;

   AST_EVENT_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|ev_o) |=> ((cause_q & $past(ev_o)) == $past(ev_o)));                 // R2
   AST_SET_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|set_v_i) |=> ((cause_q & $past(set_v_i)) == $past(set_v_i)));        // R3
   AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|clr_v_i) |=> ((cause_q & $past(clr_v_i & ~(ev_o | set_v_i))) == '0)); // R4
endmodule

// File: rtl/irq_grp_mask.sv
module irq_grp_mask #(
   parameter int NUM_SRC = 32
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] mset_v_i,
   input  logic [NUM_SRC-1:0] mclr_v_i,
   input  logic [NUM_SRC-1:0] ev_i,
   input  logic               auto_en_i,
   input  logic               abrt_wr_i,
   input  logic [NUM_SRC-1:0] wdata_i,
   output logic [NUM_SRC-1:0] mask_o,
   output logic [NUM_SRC-1:0] abrt_o
);
   logic [NUM_SRC-1:0] mask_q, abrt_q, hw_set;

   assign hw_set = auto_en_i ? ev_i : '0;

   // hardware auto-mask wins over a same-cycle software unmask of that bit
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_q <= '1;
      else         mask_q <= (mask_q & ~mclr_v_i) | mset_v_i | hw_set;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        abrt_q <= '1;
      else if (abrt_wr_i) abrt_q <= wdata_i;
   end

   assign mask_o = mask_q;
   assign abrt_o = abrt_q;

   AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|mset_v_i) |=> ((mask_q & $past(mset_v_i)) == $past(mset_v_i)));      // R5
   AST_UNMASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|mclr_v_i) |=> ((mask_q & $past(mclr_v_i & ~hw_set)) == '0));         // R6
   AST_AUTO_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (auto_en_i && (|ev_i)) |=> ((mask_q & $past(ev_i)) == $past(ev_i)));   // R11
   AST_ABORT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !abrt_wr_i |=> $stable(abrt_q));                                        // R8
endmodule

// File: rtl/irq_cause_group.sv
module irq_cause_group
   import irq_grp_pkg::*;
#(
   parameter int NUM_SRC   = 32,
   parameter bit EDGE_MODE = 1'b0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               wr_en_i,
   input  logic               rd_en_i,
   input  logic [2:0]         addr_i,
   input  logic [NUM_SRC-1:0] wdata_i,
   output logic [NUM_SRC-1:0] rdata_o,
   output logic               irq_o,
   output logic               abort_o
);
   generate
      if (NUM_SRC < CTRL_W || NUM_SRC > 64) begin : g_bad_width
         $error("irq_cause_group: NUM_SRC out of range");
      end
   endgenerate

   logic [NUM_SRC-1:0] cset_v, cclr_v, mset_v, mclr_v, clr_all;
   logic [NUM_SRC-1:0] ev, cause, mask, abrt, rd_mux, rdata_q;
   logic [CTRL_W-1:0]  ctrl_q;
   logic               abrt_wr, ctrl_wr, rd_cause, irq_q, abort_q;

   irq_grp_regdec #(.NUM_SRC(NUM_SRC)) u_dec (
      .wr_en_i   (wr_en_i),
      .rd_en_i   (rd_en_i),
      .addr_i    (addr_i),
      .wdata_i   (wdata_i),
      .cset_v_o  (cset_v),
      .cclr_v_o  (cclr_v),
      .mset_v_o  (mset_v),
      .mclr_v_o  (mclr_v),
      .abrt_wr_o (abrt_wr),
      .ctrl_wr_o (ctrl_wr),
      .rd_cause_o(rd_cause)
   );

   assign clr_all = cclr_v | ((rd_cause && ctrl_q[CTRL_COR_BIT]) ? cause : '0);

   irq_grp_cause #(.NUM_SRC(NUM_SRC), .EDGE_MODE(EDGE_MODE)) u_cause (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .src_i   (src_i),
      .set_v_i (cset_v),
      .clr_v_i (clr_all),
      .ev_o    (ev),
      .cause_o (cause)
   );

   irq_grp_mask #(.NUM_SRC(NUM_SRC)) u_mask (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mset_v_i  (mset_v),
      .mclr_v_i  (mclr_v),
      .ev_i      (ev),
      .auto_en_i (ctrl_q[CTRL_AUTO_BIT]),
      .abrt_wr_i (abrt_wr),
      .wdata_i   (wdata_i),
      .mask_o    (mask),
      .abrt_o    (abrt)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ctrl_q <= '0;
      else if (ctrl_wr) ctrl_q <= wdata_i[CTRL_W-1:0];
   end

   always_comb begin
      unique case (addr_i)
         SEL_CAUSE: rd_mux = cause;
         SEL_M_SET: rd_mux = mask;
         SEL_ABORT: rd_mux = abrt;
         SEL_CTRL:  rd_mux = {{(NUM_SRC-CTRL_W){1'b0}}, ctrl_q};
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rdata_q <= '0;
         irq_q   <= 1'b0;
         abort_q <= 1'b0;
      end else begin
         if (rd_en_i) rdata_q <= rd_mux;
         irq_q   <= |(cause & ~mask);
         abort_q <= |(cause & ~abrt);
      end
   end

   assign rdata_o = rdata_q;
   assign irq_o   = irq_q;
   assign abort_o = abort_q;

   AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(&mask) || $past(cause == '0)) |-> !irq_o);                        // R7
   AST_ABORT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(&abrt) || $past(cause == '0)) |-> !abort_o);                      // R8
   AST_SPARE_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && (addr_i == SEL_SPARE || addr_i == SEL_C_SET)) |=> (rdata_o == '0)); // R9
   AST_COR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_cause && ctrl_q[CTRL_COR_BIT] && !wr_en_i)
         |=> ((cause & $past(cause & ~ev)) == '0));                            // R10
   AST_DEAD_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && (addr_i == SEL_CAUSE || addr_i == SEL_SPARE) && !rd_en_i && (src_i == '0))
         |=> ($stable(cause) && $stable(mask) && $stable(abrt) && $stable(ctrl_q))); // R12
endmodule

// File: tb/irq_cause_group_bench.sv
module irq_cause_group_bench;
   localparam int N = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] src = '0;
   logic         wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0]   addr = '0;
   logic [N-1:0] wdata = '0;
   logic [N-1:0] rdata;
   logic         irq, abort_l;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   logic [N-1:0] m_cause, m_mask, m_abrt;
   logic [1:0]   m_ctrl;

   always #2 clk = ~clk;

   irq_cause_group u_irq_cause_group (
      .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .abort_o(abort_l)
   );

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [N-1:0] model_read(input logic [2:0] a);
      case (a)
         3'd0:    return m_cause;
         3'd3:    return m_mask;
         3'd5:    return m_abrt;
         3'd6:    return {{(N-2){1'b0}}, m_ctrl};
         default: return '0;
      endcase
   endfunction

   // one access cycle: drive after a falling edge, check just after the rising edge
   task automatic cyc(input bit wr, input bit rd, input logic [2:0] a,
                      input logic [N-1:0] wd, input logic [N-1:0] s, input string req);
      logic [N-1:0] exp_rd, clr, nc, nm;
      logic exp_irq, exp_abt;
      wr_en = wr; rd_en = rd; addr = a; wdata = wd; src = s;
      exp_rd  = model_read(a);
      exp_irq = |(m_cause & ~m_mask);
      exp_abt = |(m_cause & ~m_abrt);
      clr = ((wr && a == 3'd2) ? wd : '0) | ((rd && a == 3'd0 && m_ctrl[0]) ? m_cause : '0);
      nc  = (m_cause & ~clr) | ((wr && a == 3'd1) ? wd : '0) | s;
      nm  = (m_mask & ~((wr && a == 3'd4) ? wd : '0)) | ((wr && a == 3'd3) ? wd : '0)
            | (m_ctrl[1] ? s : '0);
      if (wr && a == 3'd5) m_abrt = wd;
      if (wr && a == 3'd6) m_ctrl = wd[1:0];
      m_cause = nc;
      m_mask  = nm;
      @(posedge clk);
      #1;
      if (rd) chk(req, rdata, exp_rd);
      chk("R7 irq", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, exp_irq});
      chk("R8 abort", {{(N-1){1'b0}}, abort_l}, {{(N-1){1'b0}}, exp_abt});
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; src = '0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      m_cause = '0; m_mask = '1; m_abrt = '1; m_ctrl = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 irq", {{(N-1){1'b0}}, irq}, '0);
      chk("R1 abort", {{(N-1){1'b0}}, abort_l}, '0);
      cyc(0, 1, 3'd0, '0, '0, "R1 cause");
      cyc(0, 1, 3'd3, '0, '0, "R1 mask");
      cyc(0, 1, 3'd5, '0, '0, "R1 abort mask");
      cyc(0, 1, 3'd6, '0, '0, "R1 ctrl");

      // R2 source pulse latches and sticks
      cyc(0, 0, 3'd0, '0, 32'h0000_0020, "R2");
      cyc(0, 0, 3'd0, '0, '0, "R2");
      cyc(0, 1, 3'd0, '0, '0, "R2 cause sticky");

      // R3 cause set
      cyc(1, 0, 3'd1, 32'h0000_F000, '0, "R3");
      cyc(0, 1, 3'd0, '0, '0, "R3 cause set");

      // R4 cause clear with colliding event on bit 13
      cyc(1, 0, 3'd2, 32'h0000_F020, 32'h0000_2000, "R4");
      cyc(0, 1, 3'd0, '0, '0, "R4 clear vs event");

      // R6 unmask, R7 irq follows one cycle later
      cyc(1, 0, 3'd4, 32'h0000_2001, '0, "R6");
      cyc(0, 1, 3'd3, '0, '0, "R6 mask clear");
      cyc(0, 0, 3'd0, '0, '0, "R7");

      // R5 mask set
      cyc(1, 0, 3'd3, 32'h0000_2000, '0, "R5");
      cyc(0, 1, 3'd3, '0, '0, "R5 mask set");

      // R8 abort mask
      cyc(1, 0, 3'd5, 32'hFFFF_DFFF, '0, "R8");
      cyc(0, 1, 3'd5, '0, '0, "R8 abort mask");
      cyc(0, 0, 3'd0, '0, '0, "R8");

      // R9 unused selects read zero
      cyc(0, 1, 3'd7, '0, '0, "R9 spare read");
      cyc(0, 1, 3'd2, '0, '0, "R9 write-only read");

      // R12 dead writes
      cyc(1, 0, 3'd0, '1, '0, "R12");
      cyc(1, 0, 3'd7, '1, '0, "R12");
      cyc(0, 1, 3'd0, '0, '0, "R12 cause");
      cyc(0, 1, 3'd3, '0, '0, "R12 mask");

      // R10 clear-on-read, event on bit 4 in the read cycle survives
      cyc(1, 0, 3'd6, 32'h1, '0, "R10");
      cyc(1, 0, 3'd1, 32'h0000_0011, '0, "R10");
      cyc(0, 1, 3'd0, '0, 32'h0000_0010, "R10 first read");
      cyc(0, 1, 3'd0, '0, '0, "R10 second read");

      // R11 auto-mask against a same-cycle unmask
      cyc(1, 0, 3'd6, 32'h2, '0, "R11");
      cyc(1, 0, 3'd4, 32'h0000_00FF, 32'h0000_0008, "R11");
      cyc(0, 1, 3'd3, '0, '0, "R11 auto mask wins");
      cyc(0, 1, 3'd6, '0, '0, "R9 ctrl read");

      // constrained random traffic
      for (int i = 0; i < 3000; i++) begin
         logic [2:0]   ra;
         logic [N-1:0] rw, rs;
         bit           dw, dr;
         ra = 3'($urandom % 8);
         dw = ($urandom % 3) == 0;
         dr = ($urandom % 3) == 0;
         rw = ($urandom % 2) ? $urandom : (N'(1) << ($urandom % N));
         rs = (($urandom % 4) == 0) ? (N'(1) << ($urandom % N)) : '0;
         cyc(dw, dr, ra, rw, rs, "R9 random read");
      end

      done = 1'b1;
      finish_run();
   end
endmodule